// File: doc/BRIEF.md
# Interrupt Flag and Mask Registers

This unit keeps the pending state of two interrupt sources for a small 8-bit core and presents it on a simple register bus. One source is an external pin. It is resynchronised and then checked for a chosen edge, or it is treated as an active-low level. The other source is a one-cycle overflow pulse from a timer that sits outside the unit. Each source owns one flag bit. A detected event sets the flag. Software clears the flag by writing a one to its bit. The core clears it when it acknowledges the matching vector.

Three byte registers can be seen on the bus: the external flag register, the timer enable register and the timer flag register. Only one bit in each register is defined. Each flag is combined with its enable and with a global interrupt-enable input to form a request line for the core. The timer, the core, vector fetch and priority arbitration all sit outside this block.

Top module: `irq_status_unit`

## Requirements
- R1: After reset every register bit is 0, every readable address returns 0x00, and both request outputs are low.
- R2: Bit positions: the external flag is bit 6 at address 0x3A, the timer overflow enable is bit 1 at address 0x39, and the timer overflow flag is bit 1 at address 0x38. The enable bit reads back the value last written to it.
- R3: Reserved bits always read 0 and ignore writes. An unmapped address reads 0x00. While the read strobe is low, the read data is 0x00.
- R4: Writing a one to a flag bit clears that flag. Writing a zero to it leaves the flag unchanged. Writing to either flag register never sets a flag.
- R5: A one-cycle acknowledge for a source clears that source's flag in the next cycle.
- R6: The external mode input selects the trigger: 00 is low level, 01 is any change, 10 is a falling edge, 11 is a rising edge. A pin change applied between clock edges is seen by the flag after exactly the third rising clock edge: two synchronizer stages plus the edge register.
- R7: In level mode the external flag reads 0 and never latches. This holds even in the first cycle after the mode is switched to level.
- R8: The timer request is high exactly when the global enable, the overflow enable and the overflow flag are all 1.
- R9: In edge modes, the external request is high exactly when the global enable, the external enable input and the external flag are all 1. In level mode, the external request is high exactly when the global enable and the external enable are 1 and the synchronised pin is low.
- R10: When a set event and a clear (a written one or an acknowledge) fall in the same cycle, the set wins and the flag is 1 afterwards.
- R11: An overflow pulse sets the timer flag at the clock edge on which the pulse is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| ext_mode | input | 2 | External trigger select (00 level, 01 any, 10 fall, 11 rise) |
| ext_en | input | 1 | External interrupt enable bit |
| glob_ie | input | 1 | Global interrupt enable |
| tmr_ovf_pulse | input | 1 | One-cycle timer overflow event |
| ack_ext | input | 1 | Core acknowledges the external vector |
| ack_tmr | input | 1 | Core acknowledges the timer overflow vector |
| req_ext | output | 1 | External interrupt request |
| req_tmr | output | 1 | Timer overflow request |

## Verification
The assertions check the following on every cycle:
- reserved and unmapped reads return zero;
- a written one or an acknowledge clears a flag unless a set arrives in the same cycle;
- a written zero keeps a flag;
- level mode empties the external flag;
- the global enable gates both requests.

Some behaviour can only be shown by the bench's scenarios. The exact three-edge latency from pin to flag is one example. Another is which transitions each edge mode accepts or ignores. The bench also shows that a level-mode request follows the pin and that a flag which is already set is hidden as soon as level mode is chosen. It sweeps all mode and transition pairs, all enable combinations and the whole address space.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    TRIG_LEVEL_LOW = 2'b00,
    TRIG_ANY       = 2'b01,
    TRIG_FALL      = 2'b10,
    TRIG_RISE      = 2'b11
  } trig_mode_e;

  localparam int NUM_SRC = 2;
  localparam int SRC_EXT = 0;
  localparam int SRC_TMR = 1;

endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_async,
  input  logic [1:0] mode,
  output logic       pin_level,
  output logic       edge_hit
);
  import irq_pkg::*;

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   rise, fall;

  // synchronizer chain next state
  always_comb begin
    sync_d[0] = pin_async;
  end

  generate
    for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
      always_comb sync_d[i] = sync_q[i-1];
    end
  endgenerate

  assign prev_d    = sync_q[SYNC_STAGES-1];
  assign pin_level = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign rise = pin_level & ~prev_q;
  assign fall = ~pin_level & prev_q;

  always_comb begin
    unique case (trig_mode_e'(mode))
      TRIG_ANY:  edge_hit = rise | fall;
      TRIG_FALL: edge_hit = fall;
      TRIG_RISE: edge_hit = rise;
      default:   edge_hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  input  logic force_clr,
  output logic flag_q
);

  logic flag_d;
  logic flag_en;

  // priority: forced clear, then set, then clear
  always_comb begin
    flag_d = flag_q;
    if (force_clr)    flag_d = 1'b0;
    else if (set_evt) flag_d = 1'b1;
    else if (clr_evt) flag_d = 1'b0;
  end

  assign flag_en = force_clr | set_evt | clr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int          ADDR_W       = 6,
  parameter int          DATA_W       = 8,
  parameter int          SYNC_STAGES  = 2,
  parameter logic [5:0]  ADDR_EXT_FLG = 6'h3A,
  parameter logic [5:0]  ADDR_TMR_MSK = 6'h39,
  parameter logic [5:0]  ADDR_TMR_FLG = 6'h38,
  parameter int          EXT_BIT      = 6,
  parameter int          OVF_BIT      = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_pin,
  input  logic [1:0]        ext_mode,
  input  logic              ext_en,
  input  logic              glob_ie,
  input  logic              tmr_ovf_pulse,
  input  logic              ack_ext,
  input  logic              ack_tmr,
  output logic              req_ext,
  output logic              req_tmr
);
  import irq_pkg::*;

  localparam int SRC_N = NUM_SRC;

  logic             sel_ext_flg, sel_tmr_msk, sel_tmr_flg;
  logic             pin_level, edge_hit, level_mode;
  logic [SRC_N-1:0] set_evt, clr_evt, force_clr, ack_vec, flag_q;
  logic             tov_en_q, tov_en_d, tov_en_we;
  logic             ext_flag_vis;
  logic [DATA_W-1:0] rdata_d;
  logic             unused_wdata_bits;

  // address decode
  assign sel_ext_flg = (bus_addr == ADDR_W'(ADDR_EXT_FLG));
  assign sel_tmr_msk = (bus_addr == ADDR_W'(ADDR_TMR_MSK));
  assign sel_tmr_flg = (bus_addr == ADDR_W'(ADDR_TMR_FLG));

  irq_pin_detect #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (ext_pin),
    .mode      (ext_mode),
    .pin_level (pin_level),
    .edge_hit  (edge_hit)
  );

  assign level_mode = (trig_mode_e'(ext_mode) == TRIG_LEVEL_LOW);

  // per-source event wiring
  assign set_evt[SRC_EXT]   = edge_hit;
  assign set_evt[SRC_TMR]   = tmr_ovf_pulse;
  assign clr_evt[SRC_EXT]   = bus_wr & sel_ext_flg & bus_wdata[EXT_BIT];
  assign clr_evt[SRC_TMR]   = bus_wr & sel_tmr_flg & bus_wdata[OVF_BIT];
  assign force_clr[SRC_EXT] = level_mode;
  assign force_clr[SRC_TMR] = 1'b0;
  assign ack_vec[SRC_EXT]   = ack_ext;
  assign ack_vec[SRC_TMR]   = ack_tmr;

  generate
    for (genvar s = 0; s < SRC_N; s++) begin : g_flag
      irq_flag_cell u_cell (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_evt   (set_evt[s]),
        .clr_evt   (clr_evt[s] | ack_vec[s]),
        .force_clr (force_clr[s]),
        .flag_q    (flag_q[s])
      );
    end
  endgenerate

  // timer overflow enable register
  assign tov_en_we = bus_wr & sel_tmr_msk;
  assign tov_en_d  = bus_wdata[OVF_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         tov_en_q <= 1'b0;
    else if (tov_en_we) tov_en_q <= tov_en_d;
  end

  // external flag hidden in level mode
  assign ext_flag_vis = flag_q[SRC_EXT] & ~level_mode;

  always_comb begin
    rdata_d = '0;
    if (bus_rd) begin
      if (sel_ext_flg) rdata_d[EXT_BIT] = ext_flag_vis;
      if (sel_tmr_msk) rdata_d[OVF_BIT] = tov_en_q;
      if (sel_tmr_flg) rdata_d[OVF_BIT] = flag_q[SRC_TMR];
    end
  end

  assign bus_rdata = rdata_d;

  // request outputs
  assign req_tmr = glob_ie & tov_en_q & flag_q[SRC_TMR];
  assign req_ext = glob_ie & ext_en & (level_mode ? ~pin_level : flag_q[SRC_EXT]);

  assign unused_wdata_bits = ^bus_wdata;

endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
  parameter int          ADDR_W       = 6,
  parameter int          DATA_W       = 8,
  parameter logic [5:0]  ADDR_EXT_FLG = 6'h3A,
  parameter logic [5:0]  ADDR_TMR_MSK = 6'h39,
  parameter logic [5:0]  ADDR_TMR_FLG = 6'h38,
  parameter int          EXT_BIT      = 6,
  parameter int          OVF_BIT      = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [1:0]        ext_mode,
  input logic              glob_ie,
  input logic              tmr_ovf_pulse,
  input logic              ack_tmr,
  input logic              req_ext,
  input logic              req_tmr,
  input logic              ext_flag,
  input logic              tmr_flag
);
  localparam logic [DATA_W-1:0] EXT_MASK = DATA_W'(1) << EXT_BIT;
  localparam logic [DATA_W-1:0] OVF_MASK = DATA_W'(1) << OVF_BIT;

  logic sel_ext, sel_msk, sel_tfl, mapped;
  assign sel_ext = (bus_addr == ADDR_W'(ADDR_EXT_FLG));
  assign sel_msk = (bus_addr == ADDR_W'(ADDR_TMR_MSK));
  assign sel_tfl = (bus_addr == ADDR_W'(ADDR_TMR_FLG));
  assign mapped  = sel_ext | sel_msk | sel_tfl;

  assert_reserved_ext_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel_ext) |-> ((bus_rdata & ~EXT_MASK) == '0));

  assert_reserved_tmr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (sel_msk || sel_tfl)) |-> ((bus_rdata & ~OVF_MASK) == '0));

  assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || !mapped) |-> (bus_rdata == '0));

  assert_w1c_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_tfl && bus_wdata[OVF_BIT] && !tmr_ovf_pulse) |=> !tmr_flag);

  assert_w0_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && sel_tfl && !bus_wdata[OVF_BIT] && tmr_flag && !ack_tmr) |=> tmr_flag);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_tmr && !tmr_ovf_pulse) |=> !tmr_flag);

  assert_level_no_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode == 2'b00) |=> !ext_flag);

  assert_gie_gates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !glob_ie |-> (!req_tmr && !req_ext));

  assert_edge_req_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode != 2'b00 && req_ext) |-> ext_flag);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf_pulse |=> tmr_flag);

endmodule

bind irq_status_unit irq_status_unit_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .ADDR_EXT_FLG(ADDR_EXT_FLG), .ADDR_TMR_MSK(ADDR_TMR_MSK), .ADDR_TMR_FLG(ADDR_TMR_FLG),
  .EXT_BIT(EXT_BIT), .OVF_BIT(OVF_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_mode(ext_mode), .glob_ie(glob_ie),
  .tmr_ovf_pulse(tmr_ovf_pulse), .ack_tmr(ack_tmr), .req_ext(req_ext), .req_tmr(req_tmr),
  .ext_flag(flag_q[0]), .tmr_flag(flag_q[1])
);

// File: tb/irq_status_unit_test.sv
`timescale 1ns/1ps
module irq_status_unit_test;

  logic       clk, rst_n;
  logic [5:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic       ext_pin, ext_en, glob_ie, tmr_ovf_pulse, ack_ext, ack_tmr;
  logic [1:0] ext_mode;
  logic       req_ext, req_tmr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  localparam logic [5:0] A_EXT = 6'h3A, A_MSK = 6'h39, A_TFL = 6'h38;

  irq_status_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin), .ext_mode(ext_mode),
    .ext_en(ext_en), .glob_ie(glob_ie), .tmr_ovf_pulse(tmr_ovf_pulse),
    .ack_ext(ack_ext), .ack_tmr(ack_tmr), .req_ext(req_ext), .req_tmr(req_tmr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd(logic [5:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic ovf_pulse();
    tmr_ovf_pulse = 1'b1;
    @(negedge clk);
    tmr_ovf_pulse = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
    ext_pin = 0; ext_mode = 2'b01; ext_en = 0; glob_ie = 0;
    tmr_ovf_pulse = 0; ack_ext = 0; ack_tmr = 0;
    tick(3);
    rst_n = 1'b1;
    tick(2);

    // R1 / R3: whole address space reads zero after reset
    for (int a = 0; a < 64; a++) begin
      rd(6'(a), d);
      chk("R1 reset read", d, 8'h00);
    end
    chk("R1 requests low", {6'b0, req_ext, req_tmr}, 8'h00);

    // R3: read data zero without strobe
    bus_addr = A_MSK; #1 chk("R3 no strobe", bus_rdata, 8'h00);

    // R2 / R3: enable bit read back, reserved ignored
    wr(A_MSK, 8'hFF); rd(A_MSK, d); chk("R2 enable bit1", d, 8'h02);
    wr(A_MSK, 8'hFD); rd(A_MSK, d); chk("R3 reserved ignored", d, 8'h00);
    // R4: writes never set flags
    wr(A_TFL, 8'hFF); rd(A_TFL, d); chk("R4 write no set tmr", d, 8'h00);
    wr(A_EXT, 8'hFF); rd(A_EXT, d); chk("R4 write no set ext", d, 8'h00);

    // R11: overflow pulse sets flag
    ovf_pulse(); rd(A_TFL, d); chk("R11 ovf sets", d, 8'h02);
    // R8: request sweep
    for (int g = 0; g < 2; g++) begin
      for (int e = 0; e < 2; e++) begin
        wr(A_MSK, (e != 0) ? 8'hFF : 8'h00);
        glob_ie = (g != 0);
        #1 chk("R8 tmr request", {7'b0, req_tmr}, 8'((g & e)));
      end
    end
    // R4: zero keeps, one clears
    wr(A_TFL, 8'hFD); rd(A_TFL, d); chk("R4 zero keeps", d, 8'h02);
    wr(A_TFL, 8'h02); rd(A_TFL, d); chk("R4 one clears", d, 8'h00);
    chk("R8 request drops", {7'b0, req_tmr}, 8'h00);
    // R5: acknowledge clears
    ovf_pulse();
    ack_tmr = 1'b1; @(negedge clk); ack_tmr = 1'b0;
    rd(A_TFL, d); chk("R5 ack clears tmr", d, 8'h00);
    // R10: set beats write-one and ack in same cycle
    tmr_ovf_pulse = 1'b1; wr(A_TFL, 8'h02); tmr_ovf_pulse = 1'b0;
    rd(A_TFL, d); chk("R10 set beats w1c", d, 8'h02);
    wr(A_TFL, 8'h02);
    tmr_ovf_pulse = 1'b1; ack_tmr = 1'b1; @(negedge clk);
    tmr_ovf_pulse = 1'b0; ack_tmr = 1'b0;
    rd(A_TFL, d); chk("R10 set beats ack", d, 8'h02);
    wr(A_TFL, 8'h02);

    // R6 / R9: edge modes over both transitions, with latency check
    glob_ie = 1; ext_en = 1;
    for (int m = 1; m < 4; m++) begin
      for (int st = 0; st < 2; st++) begin
        logic exp_hit;
        ext_mode = 2'(m);
        ext_pin = st[0];
        tick(4);
        wr(A_EXT, 8'h40);
        ext_pin = ~st[0];
        tick(2);
        rd(A_EXT, d); chk("R6 not yet after two edges", d, 8'h00);
        tick(1);
        exp_hit = (m == 1) || (m == 2 && st == 1) || (m == 3 && st == 0);
        rd(A_EXT, d); chk("R6 edge select", d, exp_hit ? 8'h40 : 8'h00);
        chk("R9 ext request edge", {7'b0, req_ext}, {7'b0, exp_hit});
      end
    end
    // pin is now 0 after the last falling transition in rise mode; set a flag
    ext_mode = 2'b01; ext_pin = 1; tick(4);
    rd(A_EXT, d); chk("R6 any change", d, 8'h40);
    ext_en = 0; #1 chk("R9 enable gates", {7'b0, req_ext}, 8'h00);
    glob_ie = 0; ext_en = 1; #1 chk("R9 global gates", {7'b0, req_ext}, 8'h00);
    glob_ie = 1;
    wr(A_EXT, 8'hBF); rd(A_EXT, d); chk("R4 ext zero keeps", d, 8'h40);
    ack_ext = 1; @(negedge clk); ack_ext = 0;
    rd(A_EXT, d); chk("R5 ack clears ext", d, 8'h00);

    // R7: flag hidden as soon as level mode is chosen
    ext_pin = 0; tick(4);
    rd(A_EXT, d); chk("R7 setup flag", d, 8'h40);
    ext_mode = 2'b00;
    rd(A_EXT, d); chk("R7 hidden at once", d, 8'h00);
    // R7 / R9: level follows pin, never latches
    for (int p = 0; p < 2; p++) begin
      ext_pin = p[0];
      tick(3);
      chk("R9 level request", {7'b0, req_ext}, {7'b0, ~p[0]});
      rd(A_EXT, d); chk("R7 level flag zero", d, 8'h00);
    end
    ext_pin = 0; tick(1); ext_pin = 1; tick(4);
    ext_mode = 2'b01; tick(1);
    rd(A_EXT, d); chk("R7 level never latched", d, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule